// File: doc/BRIEF.md
# Execute-Stage ALU with Shift Operand Steering

This block is the execute stage of a single-cycle 32-bit load/store core. It takes the two register-file read values, the full instruction word, and a 2-bit operation class from the main decoder. From these it produces a 32-bit result, the index of the register that receives the result, and a flag that is set when the result is zero. For register-format instructions it decodes the function field of the instruction word. It also adds logical left and right shifts to the arithmetic and logic set.

A shift moves the second register value (rt) by the 5-bit shift amount in instruction bits [10:6]. That shift amount is an immediate and is never read from a register. A select stage therefore places rt on the data input of the ALU during a shift and rs at all other times. The outputs are registered, so the results for an instruction appear one clock after the inputs are presented.

Top module: `exec_shift_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs load `res_q`=0, `dst_q`=0 and `zf_q`=1.
- R2: Every output is registered. The values at a rising edge come only from the inputs sampled at the previous rising edge.
- R3: When `alu_op`=2'b00, `res_q` = `rs_val` + `rt_val`, modulo 2^32, whatever the function field holds.
- R4: When `alu_op`=2'b01, `res_q` = `rs_val` - `rt_val`, modulo 2^32, whatever the function field holds.
- R5: When `alu_op`=2'b10, function field `instr[5:0]` selects the operation: 6'b100000 add, 6'b100010 subtract, 6'b100100 bitwise AND, 6'b100101 bitwise OR, 6'b101010 signed set-less-than (result 1 or 0).
- R6: When `alu_op`=2'b11 and `instr[5:0]`=6'b000000, `res_q` = `rt_val` shifted left by `instr[10:6]` with zero fill. `rs_val` has no effect.
- R7: When `alu_op`=2'b11 and `instr[5:0]`=6'b000010, `res_q` = `rt_val` shifted right by `instr[10:6]` with zero fill. `rs_val` has no effect.
- R8: A shift whose amount `instr[10:6]` is 0 returns `rt_val` unchanged.
- R9: A function code not listed for the active `alu_op` (2'b10 or 2'b11) gives `res_q`=0.
- R10: `dst_q` equals `instr[15:11]` (the rd field) of the sampled instruction.
- R11: `zf_q` is 1 exactly when the registered `res_q` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rs_val | input | 32 | First register read value (rs) |
| rt_val | input | 32 | Second register read value (rt) |
| instr | input | 32 | Full instruction word |
| alu_op | input | 2 | Operation class from the main decoder |
| res_q | output | 32 | Registered ALU result |
| dst_q | output | 5 | Registered destination register index (rd) |
| zf_q | output | 1 | Registered zero flag |

## Verification
Every result, destination index and zero flag is due exactly one rising edge after its inputs are applied. The bench changes the inputs on a falling edge and lets one rising edge capture them. It then compares all three outputs at the next falling edge, before it changes the inputs again, so each check sees exactly one capture. The embedded properties use the same one-edge relation: each compares the registered outputs with the inputs that were sampled one cycle earlier.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_SLT  = 3'd4,
    FN_SLL  = 3'd5,
    FN_SRL  = 3'd6,
    FN_NONE = 3'd7
  } alu_fn_e;

  localparam logic [1:0] CLS_ADD   = 2'b00;
  localparam logic [1:0] CLS_SUB   = 2'b01;
  localparam logic [1:0] CLS_RTYPE = 2'b10;
  localparam logic [1:0] CLS_SHIFT = 2'b11;

  localparam logic [5:0] FC_ADD = 6'b100000;
  localparam logic [5:0] FC_SUB = 6'b100010;
  localparam logic [5:0] FC_AND = 6'b100100;
  localparam logic [5:0] FC_OR  = 6'b100101;
  localparam logic [5:0] FC_SLT = 6'b101010;
  localparam logic [5:0] FC_SLL = 6'b000000;
  localparam logic [5:0] FC_SRL = 6'b000010;
endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import exec_pkg::*;
#(
  parameter int OPC_W = 2,
  parameter int FC_W  = 6
) (
  input  logic [OPC_W-1:0] alu_op,
  input  logic [FC_W-1:0]  funct,
  output alu_fn_e          fn,
  output logic             shift_sel
);
  always_comb begin
    fn = FN_NONE;
    unique case (alu_op)
      CLS_ADD: fn = FN_ADD;
      CLS_SUB: fn = FN_SUB;
      CLS_RTYPE: begin
        case (funct)
          FC_ADD:  fn = FN_ADD;
          FC_SUB:  fn = FN_SUB;
          FC_AND:  fn = FN_AND;
          FC_OR:   fn = FN_OR;
          FC_SLT:  fn = FN_SLT;
          default: fn = FN_NONE;
        endcase
      end
      default: begin
        case (funct)
          FC_SLL:  fn = FN_SLL;
          FC_SRL:  fn = FN_SRL;
          default: fn = FN_NONE;
        endcase
      end
    endcase
  end

  assign shift_sel = (fn == FN_SLL) || (fn == FN_SRL);
endmodule

// File: rtl/operand_steer.sv
module operand_steer #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [SH_W-1:0]   shamt,
  input  logic              shift_sel,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb
);
  localparam int PAD_W = DATA_W - SH_W;

  // during a shift the data input carries rt and the second input the immediate amount
  always_comb begin
    if (shift_sel) begin
      opa = rt_val;
      opb = {{PAD_W{1'b0}}, shamt};
    end else begin
      opa = rs_val;
      opb = rt_val;
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] amt;
  assign amt = opb[SH_W-1:0];

  always_comb begin
    unique case (fn)
      FN_ADD:  res = opa + opb;
      FN_SUB:  res = opa - opb;
      FN_AND:  res = opa & opb;
      FN_OR:   res = opa | opb;
      FN_SLT:  res = {{(DATA_W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      FN_SLL:  res = opa << amt;
      FN_SRL:  res = opa >> amt;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/exec_shift_alu.sv
module exec_shift_alu
  import exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_W   = 5,
  parameter int OPC_W   = 2,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic [DATA_W-1:0]  rt_val,
  input  logic [INSTR_W-1:0] instr,
  input  logic [OPC_W-1:0]   alu_op,
  output logic [DATA_W-1:0]  res_q,
  output logic [REG_W-1:0]   dst_q,
  output logic               zf_q
);
  localparam int FC_W   = 6;
  localparam int SH_W   = $clog2(DATA_W);
  localparam int SH_LO  = FC_W;
  localparam int RD_LO  = SH_LO + SH_W;

  logic [FC_W-1:0]   funct;
  logic [SH_W-1:0]   shamt;
  logic [REG_W-1:0]  rd;
  alu_fn_e           fn;
  logic              shift_sel;
  logic [DATA_W-1:0] opa, opb, res;
  logic              armed_q;

  assign funct = instr[FC_W-1:0];
  assign shamt = instr[SH_LO +: SH_W];
  assign rd    = instr[RD_LO +: REG_W];

  alu_ctrl_dec #(.OPC_W(OPC_W), .FC_W(FC_W)) u_dec (
    .alu_op(alu_op), .funct(funct), .fn(fn), .shift_sel(shift_sel)
  );

  operand_steer #(.DATA_W(DATA_W), .SH_W(SH_W)) u_steer (
    .rs_val(rs_val), .rt_val(rt_val), .shamt(shamt),
    .shift_sel(shift_sel), .opa(opa), .opb(opb)
  );

  alu_core #(.DATA_W(DATA_W)) u_core (
    .fn(fn), .opa(opa), .opb(opb), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      dst_q   <= '0;
      zf_q    <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      res_q   <= res;
      dst_q   <= rd;
      zf_q    <= (res == '0);
      armed_q <= 1'b1;
    end
  end

  // R1
  rst_state_chk: assert property (@(posedge clk) $past(rst) |-> (res_q == '0 && dst_q == '0 && zf_q));

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (zf_q == (res_q == '0)));

  // R10
  dest_field_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (dst_q == $past(instr[RD_LO +: REG_W])));

  // R6
  sll_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(alu_op) == CLS_SHIFT && $past(instr[FC_W-1:0]) == FC_SLL)
      |-> (res_q == ($past(rt_val) << $past(instr[SH_LO +: SH_W]))));

  // R7
  srl_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(alu_op) == CLS_SHIFT && $past(instr[FC_W-1:0]) == FC_SRL)
      |-> (res_q == ($past(rt_val) >> $past(instr[SH_LO +: SH_W]))));

  // R9
  bad_funct_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(alu_op) == CLS_SHIFT && $past(instr[FC_W-1:0]) != FC_SLL
      && $past(instr[FC_W-1:0]) != FC_SRL) |-> (res_q == '0));
endmodule

// File: tb/sim_exec_shift_alu.sv
module sim_exec_shift_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] rs_val, rt_val, instr;
  logic [1:0]  alu_op;
  logic [31:0] res_q;
  logic [4:0]  dst_q;
  logic        zf_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_shift_alu u0 (
    .clk(clk), .rst(rst), .rs_val(rs_val), .rt_val(rt_val),
    .instr(instr), .alu_op(alu_op), .res_q(res_q), .dst_q(dst_q), .zf_q(zf_q)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] ins, input logic [1:0] op);
    logic [5:0] f;
    logic [4:0] s;
    f = ins[5:0];
    s = ins[10:6];
    case (op)
      2'b00: return a + b;
      2'b01: return a - b;
      2'b10: case (f)
        6'b100000: return a + b;
        6'b100010: return a - b;
        6'b100100: return a & b;
        6'b100101: return a | b;
        6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default:   return 32'd0;
      endcase
      default: case (f)
        6'b000000: return b << s;
        6'b000010: return b >> s;
        default:   return 32'd0;
      endcase
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] ins, input logic [1:0] op);
    if (op == 2'b00) return "R3";
    if (op == 2'b01) return "R4";
    if (op == 2'b10) begin
      case (ins[5:0])
        6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010: return "R5";
        default: return "R9";
      endcase
    end
    if (ins[5:0] == 6'b000000) return (ins[10:6] == 5'd0) ? "R8" : "R6";
    if (ins[5:0] == 6'b000010) return (ins[10:6] == 5'd0) ? "R8" : "R7";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] ins, input logic [1:0] op);
    logic [31:0] e;
    @(negedge clk);
    rs_val = a; rt_val = b; instr = ins; alu_op = op;
    e = model(a, b, ins, op);
    @(posedge clk);
    @(negedge clk);
    // R2: result is due one edge later
    chk(tag_of(ins, op), res_q, e);
    chk("R10", {27'd0, dst_q}, {27'd0, ins[15:11]});
    chk("R11", {31'd0, zf_q}, {31'd0, (e == 32'd0)});
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rd, input logic [4:0] sh,
                                     input logic [5:0] f);
    return {16'hA5C3, rd, sh, f};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; rs_val = 32'hFFFF_FFFF; rt_val = 32'h1234_5678;
    instr = mk(5'd7, 5'd3, 6'b100000); alu_op = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", res_q, 32'd0);
    chk("R1", {27'd0, dst_q}, 32'd0);
    chk("R1", {31'd0, zf_q}, 32'd1);
    rst = 1'b0;

    // R2 one-edge latency: values seen before the capturing edge are the previous ones
    @(negedge clk);
    rs_val = 32'd5; rt_val = 32'd6; instr = mk(5'd9, 5'd0, 6'b100000); alu_op = 2'b00;
    #1;
    chk("R2", res_q, model(32'hFFFF_FFFF, 32'h1234_5678, mk(5'd7, 5'd3, 6'b100000), 2'b10));
    @(posedge clk); @(negedge clk);
    chk("R2", res_q, 32'd11);

    apply(32'hFFFF_FFFF, 32'd1, mk(5'd1, 5'd4, 6'b000010), 2'b00);   // R3 wrap, funct ignored
    apply(32'd0, 32'd1, mk(5'd2, 5'd0, 6'b000000), 2'b01);           // R4 wrap
    apply(32'd77, 32'd77, mk(5'd3, 5'd0, 6'b100000), 2'b01);         // R4 zero, R11
    apply(32'h8000_0000, 32'd1, mk(5'd4, 5'd0, 6'b101010), 2'b10);   // R5 signed slt
    apply(32'd1, 32'h8000_0000, mk(5'd5, 5'd0, 6'b101010), 2'b10);   // R5 slt false
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, mk(5'd6, 5'd0, 6'b100100), 2'b10); // R5 and
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, mk(5'd6, 5'd0, 6'b100101), 2'b10); // R5 or
    apply(32'hDEAD_BEEF, 32'h0000_0001, mk(5'd31, 5'd31, 6'b000000), 2'b11); // R6 max
    apply(32'h0000_0000, 32'h8000_0001, mk(5'd8, 5'd1, 6'b000000), 2'b11);   // R6 rs ignored
    apply(32'hFFFF_FFFF, 32'h8000_0001, mk(5'd8, 5'd1, 6'b000000), 2'b11);   // R6 rs ignored
    apply(32'h1234_5678, 32'h8000_0000, mk(5'd9, 5'd31, 6'b000010), 2'b11);  // R7 max
    apply(32'hFFFF_FFFF, 32'hF000_000F, mk(5'd9, 5'd4, 6'b000010), 2'b11);   // R7 zero fill
    apply(32'h1111_1111, 32'hCAFE_F00D, mk(5'd10, 5'd0, 6'b000000), 2'b11);  // R8 sll
    apply(32'h1111_1111, 32'hCAFE_F00D, mk(5'd10, 5'd0, 6'b000010), 2'b11);  // R8 srl
    apply(32'd3, 32'd4, mk(5'd11, 5'd2, 6'b000011), 2'b11);          // R9 shift class
    apply(32'd3, 32'd4, mk(5'd12, 5'd0, 6'b000000), 2'b10);          // R9 r-type class
    apply(32'd3, 32'd4, mk(5'd13, 5'd0, 6'b100111), 2'b10);          // R9

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins;
      logic [1:0]  op;
      logic [5:0]  f;
      op = 2'($urandom);
      case ($urandom % 9)
        0: f = 6'b100000; 1: f = 6'b100010; 2: f = 6'b100100;
        3: f = 6'b100101; 4: f = 6'b101010; 5: f = 6'b000000;
        6: f = 6'b000010; default: f = 6'($urandom);
      endcase
      ins = {$urandom} & 32'hFFFF_FFC0 | {26'd0, f};
      apply($urandom, $urandom, ins, op);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule